// File: doc/BRIEF.md
# Graphics Interrupt Status and Control Unit

This unit collects interrupt events from a graphics pipeline and presents them to a host through a small register port. The events are error conditions, the completion of a synchronising flush, flip requests and flip completions for the primary display and the overlay, vertical blank, a display event, a user interrupt and a breakpoint. Every interrupt register uses the same 16-bit bit layout: a live status view, a latched identity register, an enable register and a mask register.

The host reads registers through a combinational read path. It clears identity bits by writing ones to them, and it sets enables and masks by plain writes. A separate 4-bit error status register and error mask register feed a single error-master bit. Clearing that bit takes two steps: the host first clears the individual error, then clears the master identity bit. The unit drives one interrupt line, which is high while any enabled identity bit is set.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Only bits 15, 12, 11, 9, 7, 6, 1 and 0 exist in the 16-bit layout (implemented mask 0x9AC3). All other bits read zero and ignore writes. In the error mask, only bits 3:0 exist.
- R3: The error status register sits at address 4. Bit 0 is refresh buffer overrun, bit 1 is page table error, bit 2 is display or overlay underrun and bit 3 is instruction parser error. `err_src_i[k]` sets bit k at the clock edge. Writing one to a bit clears it, and a set in the same cycle wins over the clear.
- R4: Status bit 15 equals the OR of (error status AND NOT error mask), where the error mask is at address 5. Identity bit 15 stays set while that OR is true, so a write of one to it has no effect until the error status bit is cleared.
- R5: Status bit 12 inverts at each clock edge where `flush_done_i`, `sync_en_i` and every bit of `eng_idle_i` are all high. Each inversion latches identity bit 12.
- R6: Status bit 11 (primary) and bit 9 (overlay) set on a flip request and clear on a flip done. A request wins if both arrive in the same cycle. The identity bit latches when pending falls, not when it rises.
- R7: Status bits 7 (vertical blank), 6 (display event), 1 (user) and 0 (breakpoint) show their inputs registered once. The identity bit latches on a rising edge of the registered value.
- R8: An event whose bit is set in the mask register (address 3) does not latch its identity bit. Its status bit still updates.
- R9: Writing one to an identity bit (address 1) clears it. A set of the same bit in the same cycle takes priority.
- R10: `irq_o` is high exactly when (identity AND enable) is nonzero. The enable register is at address 2.
- R11: The status register is at address 0 and is read-only. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_src_i | input | 4 | Error condition pulses |
| flush_done_i | input | 1 | Flush completion pulse |
| sync_en_i | input | 1 | Sync-enable mode bit |
| eng_idle_i | input | NUM_ENG | Per-engine flushed indication |
| pri_flip_req_i | input | 1 | Primary flip request |
| pri_flip_done_i | input | 1 | Primary flip performed |
| ovl_flip_req_i | input | 1 | Overlay flip request |
| ovl_flip_done_i | input | 1 | Overlay flip performed |
| vblank_i | input | 1 | Primary vertical blank |
| disp_evt_i | input | 1 | Primary display event |
| user_irq_i | input | 1 | User-defined interrupt |
| brkpt_i | input | 1 | Breakpoint |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Every event input and every register write is sampled at one rising edge. The status, identity, error registers and `irq_o` all show the result right after that same edge. Reads are combinational on the address, so there is no extra read latency.

Inputs change just after a falling edge. The reference model advances on each rising edge and is compared at the next falling edge, which is where each result is due. Directed reads also happen in that half cycle, after the address has settled.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_ERR = 4;
  localparam int ADDR_W  = 3;
  localparam int NUM_LVL = 4;

  localparam int B_ERR   = 15;
  localparam int B_SYNC  = 12;
  localparam int B_PFLIP = 11;
  localparam int B_OFLIP = 9;
  localparam int B_VBL   = 7;
  localparam int B_DEVT  = 6;
  localparam int B_USER  = 1;
  localparam int B_BRK   = 0;

  localparam logic [REG_W-1:0] IMPL_MASK = 16'h9AC3;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT   = 3'd0,
    A_IDENT  = 3'd1,
    A_ENABLE = 3'd2,
    A_MASK   = 3'd3,
    A_ESTAT  = 3'd4,
    A_EMASK  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gfx_irq_err.sv
module gfx_irq_err #(
  parameter int NUM_ERR = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] err_src_i,
  input  logic               clr_we_i,
  input  logic               mask_we_i,
  input  logic [NUM_ERR-1:0] wdata_i,
  output logic [NUM_ERR-1:0] err_stat_o,
  output logic [NUM_ERR-1:0] err_mask_o,
  output logic               lvl_o,
  output logic               lvl_nxt_o
);
  logic [NUM_ERR-1:0] stat_q, stat_d, mask_q, clr_v;

  assign clr_v  = clr_we_i ? wdata_i : '0;
  // set wins over write-one-to-clear
  assign stat_d = (stat_q & ~clr_v) | err_src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign err_stat_o = stat_q;
  assign err_mask_o = mask_q;
  assign lvl_o      = |(stat_q & ~mask_q);
  assign lvl_nxt_o  = |(stat_d & ~mask_q);

  assert_err_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_src_i != '0) |=> ((stat_q & $past(err_src_i)) == $past(err_src_i)));
endmodule

// File: rtl/gfx_irq_flip.sv
module gfx_irq_flip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic done_i,
  output logic pend_o,
  output logic done_evt_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (req_i)       pend_d = 1'b1;
    else if (done_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o     = pend_q;
  assign done_evt_o = pend_q & ~pend_d;

  assert_flip_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> pend_q);
  assert_flip_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !req_i) |=> !pend_q);
endmodule

// File: rtl/gfx_irq_sync.sv
module gfx_irq_sync #(
  parameter int NUM_ENG = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_done_i,
  input  logic               sync_en_i,
  input  logic [NUM_ENG-1:0] eng_idle_i,
  output logic               sync_o,
  output logic               tog_evt_o
);
  logic sync_q;

  assign tog_evt_o = flush_done_i & sync_en_i & (&eng_idle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sync_q <= 1'b0;
    else if (tog_evt_o) sync_q <= ~sync_q;
  end

  assign sync_o = sync_q;

  assert_sync_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_done_i && sync_en_i && (&eng_idle_i)) |=> (sync_q != $past(sync_q)));
endmodule

// File: rtl/gfx_irq_lvl.sv
module gfx_irq_lvl #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
#(
  parameter int NUM_ENG = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] err_src_i,
  input  logic               flush_done_i,
  input  logic               sync_en_i,
  input  logic [NUM_ENG-1:0] eng_idle_i,
  input  logic               pri_flip_req_i,
  input  logic               pri_flip_done_i,
  input  logic               ovl_flip_req_i,
  input  logic               ovl_flip_done_i,
  input  logic               vblank_i,
  input  logic               disp_evt_i,
  input  logic               user_irq_i,
  input  logic               brkpt_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_o
);
  localparam int NUM_FLIP = 2;

  logic [REG_W-1:0] iir_q, iir_d, en_q, msk_q, stat_v, set_v, set_m, clr_v;
  logic [NUM_ERR-1:0] err_stat, err_mask;
  logic err_lvl, err_lvl_nxt;
  logic sync_lvl, sync_evt;
  logic [NUM_FLIP-1:0] flip_req, flip_done, flip_pend, flip_evt;
  logic [NUM_LVL-1:0] lvl_in, lvl_q, lvl_rise;
  logic we_ident, we_en, we_msk, we_estat, we_emask;

  assign we_ident = reg_we_i && (reg_addr_i == A_IDENT);
  assign we_en    = reg_we_i && (reg_addr_i == A_ENABLE);
  assign we_msk   = reg_we_i && (reg_addr_i == A_MASK);
  assign we_estat = reg_we_i && (reg_addr_i == A_ESTAT);
  assign we_emask = reg_we_i && (reg_addr_i == A_EMASK);

  gfx_irq_err #(.NUM_ERR(NUM_ERR)) err_i (
    .clk_i, .rst_ni,
    .err_src_i  (err_src_i),
    .clr_we_i   (we_estat),
    .mask_we_i  (we_emask),
    .wdata_i    (reg_wdata_i[NUM_ERR-1:0]),
    .err_stat_o (err_stat),
    .err_mask_o (err_mask),
    .lvl_o      (err_lvl),
    .lvl_nxt_o  (err_lvl_nxt)
  );

  gfx_irq_sync #(.NUM_ENG(NUM_ENG)) sync_i (
    .clk_i, .rst_ni,
    .flush_done_i (flush_done_i),
    .sync_en_i    (sync_en_i),
    .eng_idle_i   (eng_idle_i),
    .sync_o       (sync_lvl),
    .tog_evt_o    (sync_evt)
  );

  // index 0: primary display, 1: overlay
  assign flip_req  = {ovl_flip_req_i,  pri_flip_req_i};
  assign flip_done = {ovl_flip_done_i, pri_flip_done_i};

  for (genvar g = 0; g < NUM_FLIP; g++) begin : g_flip
    gfx_irq_flip flip_i (
      .clk_i, .rst_ni,
      .req_i      (flip_req[g]),
      .done_i     (flip_done[g]),
      .pend_o     (flip_pend[g]),
      .done_evt_o (flip_evt[g])
    );
  end

  assign lvl_in = {vblank_i, disp_evt_i, user_irq_i, brkpt_i};

  gfx_irq_lvl #(.N(NUM_LVL)) lvl_i (
    .clk_i, .rst_ni,
    .lvl_i  (lvl_in),
    .lvl_o  (lvl_q),
    .rise_o (lvl_rise)
  );

  always_comb begin
    stat_v          = '0;
    stat_v[B_ERR]   = err_lvl;
    stat_v[B_SYNC]  = sync_lvl;
    stat_v[B_PFLIP] = flip_pend[0];
    stat_v[B_OFLIP] = flip_pend[1];
    stat_v[B_VBL]   = lvl_q[3];
    stat_v[B_DEVT]  = lvl_q[2];
    stat_v[B_USER]  = lvl_q[1];
    stat_v[B_BRK]   = lvl_q[0];
  end

  // error bit is level-set, so it survives a clear while the source persists
  always_comb begin
    set_v          = '0;
    set_v[B_ERR]   = err_lvl_nxt;
    set_v[B_SYNC]  = sync_evt;
    set_v[B_PFLIP] = flip_evt[0];
    set_v[B_OFLIP] = flip_evt[1];
    set_v[B_VBL]   = lvl_rise[3];
    set_v[B_DEVT]  = lvl_rise[2];
    set_v[B_USER]  = lvl_rise[1];
    set_v[B_BRK]   = lvl_rise[0];
  end

  assign set_m = set_v & ~msk_q;
  assign clr_v = we_ident ? reg_wdata_i : '0;
  assign iir_d = ((iir_q & ~clr_v) | set_m) & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iir_q <= '0;
      en_q  <= '0;
      msk_q <= '0;
    end else begin
      iir_q <= iir_d;
      if (we_en)  en_q  <= reg_wdata_i & IMPL_MASK;
      if (we_msk) msk_q <= reg_wdata_i & IMPL_MASK;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_STAT:   reg_rdata_o = stat_v;
      A_IDENT:  reg_rdata_o = iir_q;
      A_ENABLE: reg_rdata_o = en_q;
      A_MASK:   reg_rdata_o = msk_q;
      A_ESTAT:  reg_rdata_o = {{(REG_W-NUM_ERR){1'b0}}, err_stat};
      A_EMASK:  reg_rdata_o = {{(REG_W-NUM_ERR){1'b0}}, err_mask};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(iir_q & en_q);

  assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_ident |=> ((iir_q & $past(reg_wdata_i & ~set_m)) == '0));
  assert_mask_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((iir_q & ~$past(iir_q) & $past(msk_q)) == '0));
  assert_err_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_lvl_nxt && !msk_q[B_ERR]) |=> iir_q[B_ERR]);
endmodule

// File: tb/gfx_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gfx_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  t_err = '0;
  logic        t_flush = 0, t_syncen = 0;
  logic [2:0]  t_idle = '0;
  logic        t_preq = 0, t_pdone = 0, t_oreq = 0, t_odone = 0;
  logic        t_vbl = 0, t_devt = 0, t_user = 0, t_brk = 0;
  logic [2:0]  t_addr = '0;
  logic        t_we = 0;
  logic [15:0] t_wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  gfx_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .err_src_i(t_err), .flush_done_i(t_flush), .sync_en_i(t_syncen),
    .eng_idle_i(t_idle),
    .pri_flip_req_i(t_preq), .pri_flip_done_i(t_pdone),
    .ovl_flip_req_i(t_oreq), .ovl_flip_done_i(t_odone),
    .vblank_i(t_vbl), .disp_evt_i(t_devt), .user_irq_i(t_user), .brkpt_i(t_brk),
    .reg_addr_i(t_addr), .reg_we_i(t_we), .reg_wdata_i(t_wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [3:0]  m_lvl, m_err, m_emask;
  logic        m_pp, m_op, m_sync;
  logic [15:0] m_en, m_msk, m_iir;

  always @(posedge clk or negedge rst_n) begin : model
    logic [3:0] nl, rise, ne;
    logic np, no, pd, od, tg, el;
    logic [15:0] setv, clr;
    if (!rst_n) begin
      m_lvl = '0; m_err = '0; m_emask = '0; m_pp = 0; m_op = 0; m_sync = 0;
      m_en = '0; m_msk = '0; m_iir = '0;
    end else begin
      nl   = {t_vbl, t_devt, t_user, t_brk};
      rise = nl & ~m_lvl;
      np = t_preq ? 1'b1 : (t_pdone ? 1'b0 : m_pp);
      no = t_oreq ? 1'b1 : (t_odone ? 1'b0 : m_op);
      pd = m_pp & ~np;
      od = m_op & ~no;
      tg = t_flush && t_syncen && (t_idle == 3'b111);
      ne = (m_err & ~((t_we && t_addr == 3'd4) ? t_wdata[3:0] : 4'h0)) | t_err;
      el = |(ne & ~m_emask);
      setv = '0;
      setv[15] = el; setv[12] = tg; setv[11] = pd; setv[9] = od;
      setv[7] = rise[3]; setv[6] = rise[2]; setv[1] = rise[1]; setv[0] = rise[0];
      setv = setv & ~m_msk;
      clr  = (t_we && t_addr == 3'd1) ? t_wdata : 16'h0;
      m_iir = ((m_iir & ~clr) | setv) & 16'h9AC3;
      if (t_we && t_addr == 3'd2) m_en = t_wdata & 16'h9AC3;
      if (t_we && t_addr == 3'd3) m_msk = t_wdata & 16'h9AC3;
      if (t_we && t_addr == 3'd5) m_emask = t_wdata[3:0];
      m_lvl = nl; m_pp = np; m_op = no; m_err = ne;
      if (tg) m_sync = ~m_sync;
    end
  end

  function automatic logic [15:0] m_read(logic [2:0] a);
    logic [15:0] s;
    s = '0;
    case (a)
      3'd0: begin
        s[15] = |(m_err & ~m_emask); s[12] = m_sync; s[11] = m_pp; s[9] = m_op;
        s[7] = m_lvl[3]; s[6] = m_lvl[2]; s[1] = m_lvl[1]; s[0] = m_lvl[0];
      end
      3'd1: s = m_iir;
      3'd2: s = m_en;
      3'd3: s = m_msk;
      3'd4: s = {12'h0, m_err};
      3'd5: s = {12'h0, m_emask};
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R7 status";
      3'd1: return "R9 identity";
      3'd2, 3'd3: return "R2 enable/mask";
      3'd4: return "R3 error status";
      3'd5: return "R4 error mask";
      default: return "R11 unmapped";
    endcase
  endfunction

  // compare on every clock
  bit cmp_en = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(tag_of(t_addr), rdata, m_read(t_addr));
      chk("R10 irq", {15'h0, irq}, {15'h0, |(m_iir & m_en)});
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    t_addr = a;
    #0.2;
    v = rdata;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    t_addr = a; t_we = 1; t_wdata = d;
    tick();
    t_we = 0;
  endtask

  logic [15:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 16'h0);
    end
    chk("R1 reset irq", {15'h0, irq}, 16'h0);
    cmp_en = 1;

    // R2 reserved bits
    wr(3'd2, 16'hFFFF); rd(3'd2, v); chk("R2 enable impl", v, 16'h9AC3);
    wr(3'd3, 16'hFFFF); rd(3'd3, v); chk("R2 mask impl", v, 16'h9AC3);
    wr(3'd3, 16'h0000);
    wr(3'd5, 16'hFFFF); rd(3'd5, v); chk("R2 error mask impl", v, 16'h000F);
    wr(3'd5, 16'h0000);
    wr(3'd0, 16'hFFFF); rd(3'd0, v); chk("R11 status read-only", v, 16'h0);

    // R7 level source and R10
    t_vbl = 1; tick();
    rd(3'd0, v); chk("R7 vblank status", v & 16'h0080, 16'h0080);
    rd(3'd1, v); chk("R7 vblank identity", v & 16'h0080, 16'h0080);
    chk("R10 irq on", {15'h0, irq}, 16'h1);
    wr(3'd1, 16'h0080);
    rd(3'd1, v); chk("R9 clear while held", v & 16'h0080, 16'h0);
    t_vbl = 0; tick();

    // R6 flips
    t_preq = 1; tick(); t_preq = 0;
    rd(3'd0, v); chk("R6 pri pending", v & 16'h0800, 16'h0800);
    rd(3'd1, v); chk("R6 no latch on request", v & 16'h0800, 16'h0);
    t_pdone = 1; tick(); t_pdone = 0;
    rd(3'd0, v); chk("R6 pri done status", v & 16'h0800, 16'h0);
    rd(3'd1, v); chk("R6 pri done identity", v & 16'h0800, 16'h0800);
    t_oreq = 1; t_odone = 1; tick(); t_oreq = 0; t_odone = 0;
    rd(3'd0, v); chk("R6 request priority", v & 16'h0200, 16'h0200);
    rd(3'd1, v); chk("R6 ovl no latch", v & 16'h0200, 16'h0);
    t_odone = 1; tick(); t_odone = 0;
    rd(3'd1, v); chk("R6 ovl done identity", v & 16'h0200, 16'h0200);

    // R5 sync toggle
    wr(3'd1, 16'hFFFF);
    t_syncen = 1; t_idle = 3'b101; t_flush = 1; tick(); t_flush = 0;
    rd(3'd0, v); chk("R5 no toggle engine busy", v & 16'h1000, 16'h0);
    t_idle = 3'b111; t_flush = 1; tick(); t_flush = 0;
    rd(3'd0, v); chk("R5 toggle to one", v & 16'h1000, 16'h1000);
    rd(3'd1, v); chk("R5 toggle identity", v & 16'h1000, 16'h1000);
    wr(3'd1, 16'h1000);
    t_flush = 1; tick(); t_flush = 0;
    rd(3'd0, v); chk("R5 toggle to zero", v & 16'h1000, 16'h0);
    rd(3'd1, v); chk("R5 identity on fall", v & 16'h1000, 16'h1000);
    t_syncen = 0; t_flush = 1; tick(); t_flush = 0;
    rd(3'd0, v); chk("R5 sync disabled", v & 16'h1000, 16'h0);

    // R3 / R4 errors
    wr(3'd1, 16'hFFFF);
    t_err = 4'b0010; tick(); t_err = 0;
    rd(3'd4, v); chk("R3 page table set", v, 16'h0002);
    rd(3'd0, v); chk("R4 master status", v & 16'h8000, 16'h8000);
    rd(3'd1, v); chk("R4 master identity", v & 16'h8000, 16'h8000);
    wr(3'd1, 16'h8000);
    rd(3'd1, v); chk("R4 clear blocked", v & 16'h8000, 16'h8000);
    wr(3'd4, 16'h0002);
    rd(3'd4, v); chk("R3 w1c", v, 16'h0);
    rd(3'd0, v); chk("R4 master status low", v & 16'h8000, 16'h0);
    wr(3'd1, 16'h8000);
    rd(3'd1, v); chk("R4 second step", v & 16'h8000, 16'h0);
    t_err = 4'b0100; t_addr = 3'd4; t_we = 1; t_wdata = 16'h0004; tick();
    t_err = 0; t_we = 0;
    rd(3'd4, v); chk("R3 set beats clear", v, 16'h0004);
    wr(3'd4, 16'h0004); wr(3'd1, 16'h8000);
    wr(3'd5, 16'h0001);
    t_err = 4'b0001; tick(); t_err = 0;
    rd(3'd4, v); chk("R3 masked still recorded", v, 16'h0001);
    rd(3'd0, v); chk("R4 masked error status", v & 16'h8000, 16'h0);
    rd(3'd1, v); chk("R4 masked error identity", v & 16'h8000, 16'h0);
    wr(3'd4, 16'h0001); wr(3'd5, 16'h0000);

    // R8 mask
    wr(3'd1, 16'hFFFF); wr(3'd3, 16'h0001);
    t_brk = 1; tick(); t_brk = 0;
    rd(3'd0, v); chk("R8 masked status", v & 16'h0001, 16'h0001);
    rd(3'd1, v); chk("R8 masked identity", v & 16'h0001, 16'h0);
    tick(); wr(3'd3, 16'h0000);

    // R9 set beats clear
    wr(3'd1, 16'hFFFF);
    t_user = 1; t_addr = 3'd1; t_we = 1; t_wdata = 16'h0002; tick(); t_we = 0;
    rd(3'd1, v); chk("R9 set priority", v & 16'h0002, 16'h0002);
    t_user = 0; tick();

    // R10 enable gating
    wr(3'd2, 16'h0000);
    chk("R10 disabled", {15'h0, irq}, 16'h0);
    wr(3'd2, 16'h0002);
    chk("R10 enabled", {15'h0, irq}, 16'h1);
    wr(3'd2, 16'hFFFF);

    // R11 unmapped
    rd(3'd6, v); chk("R11 addr6", v, 16'h0);
    rd(3'd7, v); chk("R11 addr7", v, 16'h0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      t_err    = ($urandom_range(0, 39) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
      t_flush  = ($urandom_range(0, 7) == 0);
      t_syncen = ($urandom_range(0, 1) == 1);
      t_idle   = ($urandom_range(0, 1) == 1) ? 3'b111 : 3'($urandom_range(0, 7));
      t_preq   = ($urandom_range(0, 5) == 0);
      t_pdone  = ($urandom_range(0, 5) == 0);
      t_oreq   = ($urandom_range(0, 5) == 0);
      t_odone  = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 4) == 0) t_vbl  = ~t_vbl;
      if ($urandom_range(0, 4) == 0) t_devt = ~t_devt;
      if ($urandom_range(0, 4) == 0) t_user = ~t_user;
      if ($urandom_range(0, 4) == 0) t_brk  = ~t_brk;
      t_addr  = 3'($urandom_range(0, 7));
      t_we    = ($urandom_range(0, 5) == 0);
      t_wdata = 16'($urandom);
      tick();
    end
    t_we = 0;
    tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule